// File: doc/BRIEF.md
# Bus SPLIT Delay Event Monitor

This block watches a shared AHB-style bus and drives two level signals into a performance counter unit. The first signal measures SPLIT delay. It goes high when a master is told to split its transfer. It stays high until that same master owns the bus again. The high time therefore covers the following:

- re-arbitration,
- transfers by other masters that are still in progress,
- any masters granted ahead of the split master.

The second signal is a one-cycle-delayed copy of the bus lock indication.

Only one split master is followed at a time. The block remembers which master was in the data phase when the SPLIT completed. While it follows that master, it ignores SPLIT responses to every other master.

The counter unit samples both outputs once per clock and accumulates them. Counting, thresholds and arbitration all lie outside this block.

Top module: `split_delay_monitor`

## Requirements
- R1: While reset is held, and on the first edge after it is released, both `splitDelayEvt` and `lockedEvt` are low.
- R2: A SPLIT response is `respCode` = 3 while `readyIn` is high. It raises `splitDelayEvt` on the next clock edge. The master recorded is the value `curMaster` held on the most recent earlier cycle that had `readyIn` high (the data-phase master).
- R3: `respCode` = 3 with `readyIn` low is the first cycle of the two-cycle response, and it does not start tracking.
- R4: Once raised, `splitDelayEvt` stays high for as many cycles as other masters occupy the bus with `readyIn` high.
- R5: `splitDelayEvt` falls on the edge after a cycle in which `curMaster` equals the recorded master and `readyIn` is high. The same index with `readyIn` low does not clear it.
- R6: A SPLIT response that arrives while tracking is active, and is not in the clearing cycle, leaves the recorded master unchanged. Granting that second master does not clear the event.
- R7: If a SPLIT response arrives in the same cycle that clears the event, `splitDelayEvt` stays high and the new data-phase master becomes the recorded master.
- R8: `lockedEvt` equals the value `lockIn` had one cycle earlier.
- R9: The other response codes never start tracking: 0 (okay), 1 (error) and 2 (retry).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| curMaster | input | 4 | Index of the master currently owning the address phase |
| respCode | input | 2 | Slave response code (3 = SPLIT) |
| readyIn | input | 1 | Bus transfer-done signal |
| lockIn | input | 1 | Bus lock indication |
| splitDelayEvt | output | 1 | High while the recorded split master waits for the bus |
| lockedEvt | output | 1 | Lock indication delayed by one cycle |

## Verification
The assertions check the following on every cycle:

- the event rises after a SPLIT when nothing is being tracked, and records the data-phase master;
- the event holds while the bus belongs to someone else;
- the event clears one edge after the recorded master is granted with ready high;
- no SPLIT with ready low, and no other response code, ever starts tracking;
- the recorded index is unchanged when a SPLIT arrives mid-tracking;
- the lock output follows its input one cycle late.

Some behaviour shows only in the bench's scenarios. These are:

- which master is actually credited after a sequence of stalled address phases;
- that a second master's grant leaves the event high;
- the hand-over to a new master when a clear and a SPLIT coincide.

A behavioural model covers all of these scenarios and a long random stretch of mixed traffic.

// File: rtl/split_mon_pkg.sv
package split_mon_pkg;

  typedef enum logic [1:0] {
    RESP_OKAY  = 2'd0,
    RESP_ERROR = 2'd1,
    RESP_RETRY = 2'd2,
    RESP_SPLIT = 2'd3
  } respKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic advanceData;  // address phase accepted: move master into data phase
    logic captureIdx;   // record data-phase master as the split master
  } monStrobe_t;

endpackage

// File: rtl/split_mon_dp.sv
module split_mon_dp #(
  parameter int MASTER_W = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [MASTER_W-1:0]           curMaster,
  input  split_mon_pkg::monStrobe_t     strobes,
  output logic [MASTER_W-1:0]           savedIdx,
  output logic [MASTER_W-1:0]           dataMaster,
  output logic                          savedMatch
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataMaster <= '0;
      savedIdx   <= '0;
    end else begin
      if (strobes.advanceData) dataMaster <= curMaster;
      if (strobes.captureIdx)  savedIdx   <= dataMaster;
    end
  end

  assign savedMatch = (curMaster == savedIdx);

endmodule

// File: rtl/split_mon_ctrl.sv
module split_mon_ctrl (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [1:0]                    respCode,
  input  logic                          readyIn,
  input  logic                          lockIn,
  input  logic                          savedMatch,
  output split_mon_pkg::monStrobe_t     strobes,
  output logic                          splitActive,
  output logic                          lockSeen
);
  import split_mon_pkg::*;

  logic splitSeen;
  logic clearNow;
  logic startNow;

  assign splitSeen = readyIn && (respCode == RESP_SPLIT);
  assign clearNow  = splitActive && readyIn && savedMatch;
  assign startNow  = splitSeen && (!splitActive || clearNow);

  always_comb begin
    strobes             = '0;
    strobes.advanceData = readyIn;
    strobes.captureIdx  = startNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      splitActive <= 1'b0;
      lockSeen    <= 1'b0;
    end else begin
      lockSeen <= lockIn;
      if (startNow)      splitActive <= 1'b1;
      else if (clearNow) splitActive <= 1'b0;
    end
  end

endmodule

// File: rtl/split_delay_monitor.sv
module split_delay_monitor #(
  parameter int MASTER_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [MASTER_W-1:0] curMaster,
  input  logic [1:0]          respCode,
  input  logic                readyIn,
  input  logic                lockIn,
  output logic                splitDelayEvt,
  output logic                lockedEvt
);
  import split_mon_pkg::*;

  monStrobe_t          strobes;
  logic [MASTER_W-1:0] savedIdx;
  logic [MASTER_W-1:0] dataMaster;
  logic                savedMatch;

  split_mon_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .respCode   (respCode),
    .readyIn    (readyIn),
    .lockIn     (lockIn),
    .savedMatch (savedMatch),
    .strobes    (strobes),
    .splitActive(splitDelayEvt),
    .lockSeen   (lockedEvt)
  );

  split_mon_dp #(.MASTER_W(MASTER_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .curMaster (curMaster),
    .strobes   (strobes),
    .savedIdx  (savedIdx),
    .dataMaster(dataMaster),
    .savedMatch(savedMatch)
  );

endmodule

// File: rtl/split_delay_monitor_chk.sv
module split_delay_monitor_chk #(
  parameter int MASTER_W = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic [MASTER_W-1:0] curMaster,
  input logic [1:0]          respCode,
  input logic                readyIn,
  input logic                lockIn,
  input logic                splitDelayEvt,
  input logic                lockedEvt,
  input logic [MASTER_W-1:0] savedIdx,
  input logic [MASTER_W-1:0] dataMaster
);

  logic chkSplit;
  logic chkGrant;
  assign chkSplit = readyIn && (respCode == 2'd3);
  assign chkGrant = readyIn && (curMaster == savedIdx);

  p_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!splitDelayEvt && chkSplit) |=> (splitDelayEvt && savedIdx == $past(dataMaster)));

  p_no_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!splitDelayEvt && !chkSplit) |=> !splitDelayEvt);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (splitDelayEvt && !chkGrant) |=> splitDelayEvt);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (splitDelayEvt && chkGrant && !chkSplit) |=> !splitDelayEvt);

  p_ignore_r6: assert property (@(posedge clk) disable iff (!rstN)
    (splitDelayEvt && !chkGrant) |=> $stable(savedIdx));

  p_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    (splitDelayEvt && chkGrant && chkSplit) |=> (splitDelayEvt && savedIdx == $past(dataMaster)));

  p_lock_on_r8: assert property (@(posedge clk) disable iff (!rstN)
    lockIn |=> lockedEvt);

  p_lock_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !lockIn |=> !lockedEvt);

endmodule

bind split_delay_monitor split_delay_monitor_chk #(.MASTER_W(MASTER_W)) u_chk (.*);

// File: tb/split_delay_monitor_tb.sv
module split_delay_monitor_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [MW-1:0] curMaster = '0;
  logic [1:0]    respCode = 2'd0;
  logic          readyIn = 1'b0;
  logic          lockIn = 1'b0;
  logic          splitDelayEvt;
  logic          lockedEvt;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;
  string curTag = "R1";

  // behavioural reference
  int mdlData = 0;
  int mdlSaved = 0;
  bit mdlActive = 0;
  bit mdlLock = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  split_delay_monitor #(.MASTER_W(MW)) u_dut (
    .clk(clk), .rstN(rstN), .curMaster(curMaster), .respCode(respCode),
    .readyIn(readyIn), .lockIn(lockIn),
    .splitDelayEvt(splitDelayEvt), .lockedEvt(lockedEvt)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mdlData = 0; mdlSaved = 0; mdlActive = 0; mdlLock = 0;
    end else begin
      bit isSplit;
      bit isGrant;
      isSplit = readyIn && respCode == 2'd3;
      isGrant = mdlActive && readyIn && (int'(curMaster) == mdlSaved);
      mdlLock = lockIn;
      if (isSplit && (!mdlActive || isGrant)) begin
        mdlActive = 1; mdlSaved = mdlData;
      end else if (isGrant) begin
        mdlActive = 0;
      end
      if (readyIn) mdlData = int'(curMaster);
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  task automatic compareModel();
    check(curTag, "splitDelayEvt vs model", int'(splitDelayEvt), int'(mdlActive));
    check(curTag, "lockedEvt vs model", int'(lockedEvt), int'(mdlLock));
  endtask

  // drive one cycle: inputs set at negedge, outputs compared at following negedge
  task automatic cyc(int m, int r, bit rdy, bit lk);
    curMaster = m[MW-1:0];
    respCode  = r[1:0];
    readyIn   = rdy;
    lockIn    = lk;
    @(posedge clk);
    @(negedge clk);
    cycles++;
    compareModel();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "splitDelayEvt in reset", int'(splitDelayEvt), 0);
    check("R1", "lockedEvt in reset", int'(lockedEvt), 0);
    rstN = 1'b1;
    curTag = "R1";
    cyc(0, 0, 1, 0);
    check("R1", "splitDelayEvt after reset", int'(splitDelayEvt), 0);
    check("R1", "lockedEvt after reset", int'(lockedEvt), 0);

    // R3 then R2: master 2 in data phase, two-cycle split
    curTag = "R2";
    cyc(2, 0, 1, 0);
    curTag = "R3";
    cyc(5, 3, 0, 0);
    check("R3", "no start on first split cycle", int'(splitDelayEvt), 0);
    curTag = "R2";
    cyc(5, 3, 1, 0);
    check("R2", "event raised", int'(splitDelayEvt), 1);
    // R4: others own the bus
    curTag = "R4";
    cyc(5, 0, 1, 0);
    cyc(7, 0, 1, 0);
    cyc(5, 0, 0, 0);
    check("R4", "held during other masters", int'(splitDelayEvt), 1);
    // R5: index 2 with ready low does not clear, then with ready high clears
    curTag = "R5";
    cyc(2, 0, 0, 0);
    check("R5", "no clear while ready low", int'(splitDelayEvt), 1);
    cyc(2, 0, 1, 0);
    check("R5", "cleared after grant", int'(splitDelayEvt), 0);

    // R9: other codes ignored
    curTag = "R9";
    cyc(4, 0, 1, 0);
    cyc(4, 1, 1, 0);
    cyc(4, 2, 1, 0);
    check("R9", "no start on non-split codes", int'(splitDelayEvt), 0);

    // R6: track master 3, ignore split to master 4
    curTag = "R6";
    cyc(3, 0, 1, 0);
    cyc(4, 3, 1, 0);
    check("R6", "tracking master 3", int'(splitDelayEvt), 1);
    cyc(8, 3, 1, 0);
    cyc(4, 0, 1, 0);
    check("R6", "second master grant does not clear", int'(splitDelayEvt), 1);
    cyc(3, 0, 1, 0);
    check("R6", "original master clears", int'(splitDelayEvt), 0);

    // R7: track 6, then clear cycle coincides with split of master 9
    curTag = "R7";
    cyc(6, 0, 1, 0);
    cyc(1, 3, 1, 0);
    cyc(9, 0, 1, 0);
    cyc(6, 3, 1, 0);
    check("R7", "restart keeps event high", int'(splitDelayEvt), 1);
    cyc(6, 0, 1, 0);
    check("R7", "old master no longer clears", int'(splitDelayEvt), 1);
    cyc(9, 0, 1, 0);
    check("R7", "new master clears", int'(splitDelayEvt), 0);

    // R8: lock follows one cycle later
    curTag = "R8";
    cyc(0, 0, 1, 1);
    check("R8", "lock high delayed", int'(lockedEvt), 1);
    cyc(0, 0, 0, 0);
    check("R8", "lock low delayed", int'(lockedEvt), 0);
    cyc(0, 0, 0, 1);
    check("R8", "lock independent of ready", int'(lockedEvt), 1);

    // mixed traffic against the model
    curTag = "R4";
    for (int i = 0; i < 600; i++) begin
      int m;
      int r;
      m = int'($urandom_range(0, 15));
      r = ($urandom_range(0, 3) == 0) ? 3 : int'($urandom_range(0, 2));
      cyc(m, r, bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 1)));
    end

    finishRun();
  end

endmodule